// File: doc/BRIEF.md
# Host Serial Memory Access Port for an On-Screen Display

This block lets a host controller read and write a 16K-byte internal address space over a two-wire I2C bus. The space holds display RAM, a glyph ROM and control registers. The block answers one fixed 7-bit device address. A write transaction carries a two-byte internal pointer, low byte first, followed by any number of data bytes, which go to consecutive locations. A read is done in two transactions. The first loads the pointer and carries no data. The second sets the read flag and streams bytes from successive locations, starting at the pointer.

Each data byte reaches the memory in step with the horizontal sync strobe, so the host can change memory while a page is on screen without disturbing the display fetches. While a byte is waiting for its strobe, the block holds SCL low. The address map is decoded at the memory port. Writes that target ROM or unmapped space are acknowledged but never reach the memory. Reads of unmapped space return zero without a request.

Top module: `osd_i2c_port`

## Requirements
- R1: The block acknowledges only the device address 1011101 (write byte BAh, read byte BBh). Any other address gets no acknowledge, and the block ignores the bus until the next start condition.
- R2: In a write transaction, the byte after the device address sets pointer bits 7..0. The next byte sets pointer bits 13..8 from its bits 5..0. Every following byte is acknowledged and written to the pointer, which then advances by one.
- R3: A memory request is only issued in the cycle after an HSYNC strobe, lasts one cycle, and no request is issued that a received data byte or a read fetch does not call for.
- R4: SCL is held low from the falling edge that ends a write data byte until that byte has been committed on a strobe. In a read, SCL is held low from the falling edge that ends an acknowledge until the next byte has been fetched.
- R5: A transaction with the read flag returns bytes from successive locations, starting at the pointer left by the previous transaction. The first byte is fetched on the first strobe after the device address acknowledge.
- R6: Writes to locations outside RAM (0000h–03FFh) and the register window (3FD0h–3FFFh) are acknowledged and produce no write request, and the pointer still advances past them.
- R7: Reads in the ROM window (0800h–3FBFh) issue a read request like RAM and registers do. Reads of unmapped locations (0400h–07FFh, 3FC0h–3FCFh) return 00h and issue no request.
- R8: When the host does not acknowledge a read byte, the block fetches nothing more, leaves SDA and SCL released, and waits for the next start condition.
- R9: Outside start and stop conditions, the block changes its SDA drive only while SCL is low.
- R10: The pointer wraps from 3FFFh to 0000h.
- R11: After a synchronous active-low reset, SDA and SCL are released and no memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| hsync_i | input | 1 | One-cycle horizontal sync strobe that paces memory transfers |
| scl_oe | output | 1 | When high, pulls SCL low (clock stretching) |
| sda_oe | output | 1 | When high, pulls SDA low (open drain) |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write when high, a read when low |
| mem_addr | output | 14 | Internal address of the request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle mem_req is high |

## Verification
A wrong pointer or byte-kind state shows at the memory port at the next strobe after the byte concerned, as a request with the wrong address, the wrong data or the wrong direction. A scoreboard of expected requests catches this in the cycle the request appears. A bad stretch or acknowledge state shows on the bus within one bit time, as a missing acknowledge or as SCL released before the strobe. Read-side errors show as wrong bytes returned to the host, and as requests that appear after a refused byte.

// File: rtl/osd_i2c_pkg.sv
// Package: shared types for the serial memory access port.
// Assumes: one byte-kind sequence per transaction (device, pointer low,
// pointer high, data...).
package osd_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_RECV,   // shifting in a byte from the host
        ST_ACK,    // driving acknowledge, possibly stretching for a commit
        ST_FETCH,  // stretching until the strobe allows a read fetch
        ST_LOAD,   // capturing fetched byte
        ST_SEND,   // shifting a byte out to the host
        ST_RACK    // sampling the host acknowledge
    } port_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_PLO,
        K_PHI,
        K_DATA
    } byte_kind_e;

    // Advance the meaning of the next received byte.
    function automatic byte_kind_e next_kind(input byte_kind_e k);
        case (k)
            K_DEV:   return K_PLO;
            K_PLO:   return K_PHI;
            default: return K_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the system clock domain through a chain of
// flip-flops and derives edge and bus-condition pulses.
// Assumes: clk is many times faster than SCL; STAGES >= 2.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int LINES = 2;

    logic [LINES-1:0] pins;
    logic [LINES-1:0] synced;
    logic             scl_q;
    logic             sda_q;

    assign pins = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the raw line through the synchroniser chain (idle bus is high).
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pins[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    // Keep one more sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s && !scl_q;
    assign scl_fall = !scl_s && scl_q;
    assign start_p  = scl_s && scl_q && sda_q && !sda_s;
    assign stop_p   = scl_s && scl_q && !sda_q && sda_s;

endmodule

// File: rtl/osd_region_dec.sv
// Module: osd_region_dec
// Classifies an internal address as writable (RAM, registers) and/or
// readable (RAM, ROM, registers). Anything else is unmapped.
// Assumes: windows are ordered RAM < ROM < registers and do not overlap.
module osd_region_dec #(
    parameter int                ADDR_W  = 14,
    parameter logic [ADDR_W-1:0] RAM_TOP = 14'h03FF,
    parameter logic [ADDR_W-1:0] ROM_LO  = 14'h0800,
    parameter logic [ADDR_W-1:0] ROM_HI  = 14'h3FBF,
    parameter logic [ADDR_W-1:0] REG_LO  = 14'h3FD0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              wr_ok_o,
    output logic              rd_ok_o
);
    logic in_ram;
    logic in_rom;
    logic in_reg;

    // Window compare for each region.
    always_comb begin
        in_ram  = (addr_i <= RAM_TOP);
        in_rom  = (addr_i >= ROM_LO) && (addr_i <= ROM_HI);
        in_reg  = (addr_i >= REG_LO);
        wr_ok_o = in_ram || in_reg;
        rd_ok_o = in_ram || in_rom || in_reg;
    end

endmodule

// File: rtl/osd_i2c_port.sv
// Module: osd_i2c_port
// I2C slave that reads and writes a 14-bit internal address space. Data
// bytes are transferred to or from memory only on an HSYNC strobe, with
// SCL stretched until that happens.
// Assumes: mem_rdata is valid combinationally while mem_req is high;
// hsync_i is a one-cycle strobe; SCL is much slower than clk.
module osd_i2c_port
    import osd_i2c_pkg::*;
#(
    parameter int                ADDR_W      = 14,
    parameter logic [6:0]        DEV_ADDR    = 7'b1011101,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] RAM_TOP     = 14'h03FF,
    parameter logic [ADDR_W-1:0] ROM_LO      = 14'h0800,
    parameter logic [ADDR_W-1:0] ROM_HI      = 14'h3FBF,
    parameter logic [ADDR_W-1:0] REG_LO      = 14'h3FD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              hsync_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int                HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] ONE  = 1;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic              wr_ok, rd_ok;
    port_state_e       st;
    byte_kind_e        kind;
    logic [2:0]        bitcnt;
    logic              full;
    logic [7:0]        shreg;
    logic [7:0]        wbuf;
    logic [ADDR_W-1:0] ptr;
    logic              rd_flag;
    logic              pend;
    logic              hit;
    logic              nack;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    osd_region_dec #(
        .ADDR_W  (ADDR_W),
        .RAM_TOP (RAM_TOP),
        .ROM_LO  (ROM_LO),
        .ROM_HI  (ROM_HI),
        .REG_LO  (REG_LO)
    ) u_dec (
        .addr_i  (ptr),
        .wr_ok_o (wr_ok),
        .rd_ok_o (rd_ok)
    );

    // Bus pulls: acknowledge, outgoing zero bits and clock stretching.
    assign sda_oe = (st == ST_ACK) || ((st == ST_SEND) && !shreg[7]);
    assign scl_oe = ((st == ST_ACK) && pend) || (st == ST_FETCH) || (st == ST_LOAD);

    // Transaction sequencer and HSYNC-paced memory port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind      <= K_DEV;
            bitcnt    <= '0;
            full      <= 1'b0;
            shreg     <= '0;
            wbuf      <= '0;
            ptr       <= '0;
            rd_flag   <= 1'b0;
            pend      <= 1'b0;
            hit       <= 1'b0;
            nack      <= 1'b0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_req <= 1'b0;
            if (start_p) begin
                st     <= ST_RECV;
                kind   <= K_DEV;
                bitcnt <= '0;
                full   <= 1'b0;
                pend   <= 1'b0;
            end else if (stop_p) begin
                st   <= ST_IDLE;
                pend <= 1'b0;
            end else begin
                case (st)
                    ST_RECV: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full <= 1'b0;
                            st   <= ST_ACK;
                            case (kind)
                                K_DEV: begin
                                    rd_flag <= shreg[0];
                                    if (shreg[7:1] != DEV_ADDR) st <= ST_IDLE;
                                end
                                K_PLO:   ptr[7:0]        <= shreg;
                                K_PHI:   ptr[ADDR_W-1:8] <= shreg[HI_W-1:0];
                                default: begin
                                    wbuf <= shreg;
                                    pend <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (pend && hsync_i) begin
                            pend <= 1'b0;
                            ptr  <= ptr + ONE;
                            if (wr_ok) begin
                                mem_req   <= 1'b1;
                                mem_we    <= 1'b1;
                                mem_addr  <= ptr;
                                mem_wdata <= wbuf;
                            end
                        end else if (scl_fall && !pend) begin
                            if (kind == K_DEV && rd_flag) begin
                                st <= ST_FETCH;
                            end else begin
                                st     <= ST_RECV;
                                bitcnt <= '0;
                                kind   <= next_kind(kind);
                            end
                        end
                    end
                    ST_FETCH: begin
                        if (hsync_i) begin
                            hit <= rd_ok;
                            st  <= ST_LOAD;
                            if (rd_ok) begin
                                mem_req  <= 1'b1;
                                mem_we   <= 1'b0;
                                mem_addr <= ptr;
                            end
                        end
                    end
                    ST_LOAD: begin
                        shreg  <= hit ? mem_rdata : 8'h00;
                        ptr    <= ptr + ONE;
                        bitcnt <= '0;
                        st     <= ST_SEND;
                    end
                    ST_SEND: begin
                        if (scl_fall) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) st <= ST_RACK;
                            else                shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise)      nack <= sda_s;
                        else if (scl_fall) st   <= nack ? ST_IDLE : ST_FETCH;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_REQ_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(hsync_i)) else $error("request without strobe"); // R3
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req) else $error("request longer than a cycle"); // R3
    AST_WR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr <= RAM_TOP || mem_addr >= REG_LO)) else $error("write outside writable window"); // R6
    AST_SDA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_p) && !$past(stop_p)) |-> $stable(sda_oe)) else $error("SDA moved while SCL high"); // R9
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_s) else $error("stretch began with SCL high"); // R4

endmodule

// File: tb/test_osd_i2c_port.sv
// Bench: a host model drives transactions and pushes expected memory
// requests into a scoreboard; a monitor pops and compares them.
module test_osd_i2c_port;
    localparam int Q      = 12;
    localparam int HS_PER = 400;

    typedef struct packed {
        logic        we;
        logic [13:0] addr;
        logic [7:0]  data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_host = 1'b1;
    logic        sda_host = 1'b1;
    logic        hsync = 1'b0;
    logic        scl_line, sda_line;
    logic        scl_oe, sda_oe, mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  ram  [0:1023];
    logic [7:0]  regs [0:47];
    logic [7:0]  wb   [0:3];
    item_t       sbq[$];
    item_t       mon_e;
    int          checks = 0;
    int          errors = 0;
    int          viol = 0;
    bit          done = 1'b0;
    logic        hs_prev = 1'b0, scl_prev = 1'b1, oe_prev = 1'b0;

    always #5 clk = ~clk;

    assign scl_line = scl_host & ~scl_oe;
    assign sda_line = sda_host & ~sda_oe;

    function automatic logic writable(input logic [13:0] a);
        return (a <= 14'h03FF) || (a >= 14'h3FD0);
    endfunction
    function automatic logic readable(input logic [13:0] a);
        return writable(a) || (a >= 14'h0800 && a <= 14'h3FBF);
    endfunction
    function automatic logic [7:0] rom_byte(input logic [13:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
    endfunction
    function automatic logic [7:0] model_rd(input logic [13:0] a);
        logic [13:0] off;
        off = a - 14'h3FD0;
        if (a <= 14'h03FF)      return ram[a[9:0]];
        else if (a >= 14'h3FD0) return regs[off[5:0]];
        else if (readable(a))   return rom_byte(a);
        else                    return 8'h00;
    endfunction

    assign mem_rdata = model_rd(mem_addr);

    osd_i2c_port i_osd_i2c_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .hsync_i   (hsync),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    initial begin
        for (int i = 0; i < 1024; i++) ram[i] = i[7:0] ^ 8'h3C;
        for (int i = 0; i < 48; i++) regs[i] = 8'h00;
    end

    // HSYNC strobe source
    initial begin
        forever begin
            repeat (HS_PER - 1) @(posedge clk);
            #1 hsync = 1'b1;
            @(posedge clk);
            #1 hsync = 1'b0;
        end
    end

    // Monitor: scoreboard pop at each request, SDA discipline tally
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                checks++;
                if (!hs_prev) begin
                    errors++;
                    $display("FAIL R3 request at %0h with no strobe: actual 0 expected 1", mem_addr);
                end
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL R3 unexpected request: actual addr %0h we %0b expected none", mem_addr, mem_we);
                end else begin
                    mon_e = sbq.pop_front();
                    if (mon_e.we != mem_we || mon_e.addr != mem_addr || (mem_we && mon_e.data != mem_wdata)) begin
                        errors++;
                        $display("FAIL %s request: actual we %0b addr %0h data %0h expected we %0b addr %0h data %0h",
                                 mem_we ? "R2" : "R5", mem_we, mem_addr, mem_wdata, mon_e.we, mon_e.addr, mon_e.data);
                    end
                end
                if (mem_we) begin
                    if (mem_addr <= 14'h03FF)      ram[mem_addr[9:0]] = mem_wdata;
                    else if (mem_addr >= 14'h3FD0) regs[mem_addr[5:0] - 6'h10] = mem_wdata;
                end
            end
            if (scl_line && scl_prev && sda_oe != oe_prev) viol++;
        end
        hs_prev  = hsync;
        scl_prev = scl_line;
        oe_prev  = sda_oe;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clk_pulse(output logic s, output int w);
        scl_host = 1'b1;
        w = 0;
        tick();
        while (!scl_line) begin
            w++;
            tick();
        end
        repeat (Q) tick();
        s = sda_line;
        repeat (Q) tick();
        scl_host = 1'b0;
        repeat (2) tick();
    endtask

    task automatic bus_start();
        sda_host = 1'b1;
        scl_host = 1'b1;
        tick();
        while (!scl_line) tick();
        repeat (Q) tick();
        sda_host = 1'b0;
        repeat (Q) tick();
        scl_host = 1'b0;
        repeat (Q) tick();
    endtask

    task automatic bus_stop();
        sda_host = 1'b0;
        repeat (Q) tick();
        scl_host = 1'b1;
        tick();
        while (!scl_line) tick();
        repeat (Q) tick();
        sda_host = 1'b1;
        repeat (Q) tick();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output int w);
        logic s;
        int   wi;
        for (int i = 7; i >= 0; i--) begin
            sda_host = b[i];
            repeat (Q) tick();
            clk_pulse(s, wi);
        end
        sda_host = 1'b1;
        repeat (Q) tick();
        clk_pulse(s, w);
        ack = !s;
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] b, output int w_first);
        logic s;
        int   wi;
        sda_host = 1'b1;
        w_first  = 0;
        for (int i = 7; i >= 0; i--) begin
            repeat (Q) tick();
            clk_pulse(s, wi);
            b[i] = s;
            if (i == 7) w_first = wi;
        end
        sda_host = ack_it ? 1'b0 : 1'b1;
        repeat (Q) tick();
        clk_pulse(s, wi);
        sda_host = 1'b1;
    endtask

    task automatic set_pointer(input logic [13:0] a);
        logic ack;
        int   w;
        send_byte(8'hBA, ack, w);
        check(ack, "R1", "device address acknowledge", ack, 1);
        send_byte(a[7:0], ack, w);
        check(ack && w == 0, "R2", "pointer low acknowledge without stretch", {ack, w[7:0]}, 1);
        send_byte({2'b00, a[13:8]}, ack, w);
        check(ack && w == 0, "R2", "pointer high acknowledge without stretch", {ack, w[7:0]}, 1);
    endtask

    task automatic do_write(input logic [13:0] a, input int n);
        logic [13:0] cur;
        logic        ack;
        int          w;
        bus_start();
        set_pointer(a);
        cur = a;
        for (int k = 0; k < n; k++) begin
            if (writable(cur)) sbq.push_back('{we: 1'b1, addr: cur, data: wb[k]});
            send_byte(wb[k], ack, w);
            check(ack, writable(cur) ? "R2" : "R6", "data byte acknowledge", ack, 1);
            check(w > 0, "R4", "SCL held until strobe commit", w, 1);
            cur = cur + 14'd1;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [13:0] a, input int n, input bit hold);
        logic [13:0] cur;
        logic [7:0]  b;
        logic        ack;
        int          w;
        bus_start();
        set_pointer(a);
        bus_stop();
        bus_start();
        send_byte(8'hBB, ack, w);
        check(ack, "R5", "read device address acknowledge", ack, 1);
        cur = a;
        for (int k = 0; k < n; k++) begin
            if (readable(cur)) sbq.push_back('{we: 1'b0, addr: cur, data: 8'h00});
            recv_byte(k < n - 1, b, w);
            check(b == model_rd(cur), (readable(cur) && cur <= 14'h0800) || cur >= 14'h3FD0 ? "R5" : "R7",
                  "read byte", b, model_rd(cur));
            if (k == 0) check(w > 0, "R4", "SCL held until first fetch", w, 1);
            cur = cur + 14'd1;
        end
        if (hold) begin
            // R8: after the refused byte, no fetch and nothing driven
            for (int t = 0; t < 3 * HS_PER; t++) begin
                tick();
                if (sda_oe || scl_oe) begin
                    check(1'b0, "R8", "bus released after host NACK", {sda_oe, scl_oe}, 0);
                    break;
                end
            end
            check(!sda_oe && !scl_oe, "R8", "released after waiting three lines", {sda_oe, scl_oe}, 0);
        end
        bus_stop();
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        int   w;
        repeat (5) tick();
        rst_n = 1'b1;
        repeat (3) tick();
        check(!sda_oe, "R11", "SDA released after reset", sda_oe, 0);
        check(!scl_oe, "R11", "SCL released after reset", scl_oe, 0);
        check(!mem_req, "R11", "no request after reset", mem_req, 0);

        // R2 R4: RAM burst with auto-increment
        wb[0] = 8'hA5; wb[1] = 8'h3C; wb[2] = 8'hF0;
        do_write(14'h0123, 3);
        // R2: register window
        wb[0] = 8'h11; wb[1] = 8'h22;
        do_write(14'h3FD5, 2);

        // R1: foreign device address is refused and ignored
        bus_start();
        send_byte(8'hB8, ack, w);
        check(!ack, "R1", "foreign address not acknowledged", ack, 0);
        send_byte(8'h55, ack, w);
        check(!ack, "R1", "bytes after foreign address ignored", ack, 0);
        bus_stop();

        // R6: RAM end into unmapped space, unmapped into registers
        wb[0] = 8'hAA; wb[1] = 8'hBB;
        do_write(14'h03FF, 2);
        wb[0] = 8'h01; wb[1] = 8'h5C;
        do_write(14'h3FCF, 2);
        check(regs[0] == 8'h5C, "R6", "pointer advanced past discarded byte", regs[0], 8'h5C);
        wb[0] = 8'h42;
        do_write(14'h0900, 1);

        // R10: wrap from the top of the space
        wb[0] = 8'h99; wb[1] = 8'h66;
        do_write(14'h3FFF, 2);
        check(ram[0] == 8'h66, "R10", "byte after 3FFF lands at 0000", ram[0], 8'h66);
        check(regs[47] == 8'h99, "R10", "byte at 3FFF", regs[47], 8'h99);

        // R5: read back the burst
        do_read(14'h0123, 3, 1'b0);
        // R7: RAM end, then unmapped reads as zero without request
        do_read(14'h03FE, 3, 1'b0);
        // R7: ROM window is fetched; earlier write there was discarded
        do_read(14'h0900, 2, 1'b0);
        // R8: NACK ends the read
        do_read(14'h3FD5, 2, 1'b1);

        repeat (2 * HS_PER) tick();
        check(sbq.size() == 0, "R3", "all expected requests seen", sbq.size(), 0);
        check(viol == 0, "R9", "SDA drive changes while SCL high", viol, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule